// File: doc/BRIEF.md
# Per-Bank Auto-Close Timing Tracker

This block sits beside the command scheduler of a multi-bank DRAM controller and follows every bank from activation to closure. It watches the stream of issued commands: row open, column read and column write. Each command carries a bank index and a close-after-burst flag. From these it decides, for each bank, the cycle in which the bank starts closing itself. No explicit close command is needed. A read or write that sets the flag closes the bank once its data burst has finished, but never before the minimum row-active time counted from the row-open command. A write also waits a recovery interval after its last data beat.

The block reports each internal close with a one-cycle start pulse for that bank. A per-bank ready flag then stays low for the row-precharge interval, and the scheduler must hold back commands to that bank while it is low. Every bank has its own state and counters. The other banks keep taking commands while one bank is closing. All intervals are parameters counted in clock cycles. There is no data stream here: the command inputs and all outputs are plain control pins sampled every cycle, with no back-pressure.

Top module: `ap_bank_tracker`

## Requirements
- R1: A command is presented by raising cmd_valid for one cycle, with cmd_kind 1 = row open, 2 = read and 3 = write (0 is no operation). The bank is selected by cmd_bank. A row open sent to an idle bank with ready high makes bank_open of that bank high from the next cycle.
- R2: A read or write sent to an open bank with cmd_ap low leaves the bank open. It produces no pre_start, and bank_ready stays high.
- R3: The close request belongs only to the command that carries it. After the bank has closed and been reopened, a later read or write without cmd_ap does not close it.
- R4: For a read with cmd_ap sent after a row open in cycle A, let D be the cycle in which burst_done of that bank is high. Then pre_start of that bank rises in cycle max(D+1, A+TRAS).
- R5: For a write with cmd_ap under the same conditions, pre_start rises in cycle max(D+1+TWR, A+TRAS).
- R6: pre_start of a bank is a single-cycle pulse. It never occurs earlier than TRAS cycles after the row open it closes.
- R7: bank_ready of a bank is low for exactly TRP consecutive cycles, starting with the pre_start cycle. bank_open falls right after the pre_start cycle, and the bank is then idle.
- R8: A command sent to a bank in a state that does not accept it has no effect. Row open is accepted only when the bank is idle and ready. Read and write are accepted only when the bank is open and not already set to close. burst_done has no effect unless a close is pending on that bank.
- R9: Commands to other banks are accepted while one bank is waiting to close or is closing. They do not change that bank's pre_start cycle or its ready window.
- R10: During and right after reset, every bank is idle: bank_open is low, bank_ready is high and pre_start is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_kind | input | 2 | 0 none, 1 row open, 2 read, 3 write |
| cmd_bank | input | BW | Target bank index |
| cmd_ap | input | 1 | Close the bank after this read or write |
| burst_done | input | NBANK | Per bank: last data beat of the current burst |
| pre_start | output | NBANK | Per bank: internal close starts this cycle |
| bank_ready | output | NBANK | Per bank: bank may take a new command |
| bank_open | output | NBANK | Per bank: a row is open |

## Verification
The bound checker covers, on every cycle and for every bank, the rules that follow from history alone. A close start lasts one cycle, comes only to an open bank and never arrives before the row-active minimum. Every low stretch of ready lasts exactly the precharge interval, and an open bank is only ever left through a close start. The exact cycle of each close depends on when the burst ends and on whether the command was a read or a write. The bench shows this by sweeping bank, command type, flag and burst length. The same scenarios show that commands to a busy bank are ignored, that the close request does not carry over to later commands, and that neighbouring banks work on independently.

// File: rtl/ap_trk_pkg.sv
package ap_trk_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } cmd_kind_e;

  typedef enum logic [2:0] {
    BK_IDLE,
    BK_OPEN,
    BK_ARMED,
    BK_DRAIN,
    BK_CLOSE
  } bank_state_e;

  typedef struct packed {
    logic act;
    logic rw;
    logic wr;
    logic ap;
  } bank_req_t;

endpackage

// File: rtl/ap_down_timer.sv
module ap_down_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic [W-1:0] count,
  output logic         zero
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (en && (count != '0)) begin
      count <= count - 1'b1;
    end
  end

  assign zero = (count == '0);

endmodule

// File: rtl/ap_cmd_decode.sv
module ap_cmd_decode
  import ap_trk_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int BW    = 2
) (
  input  logic                        cmd_valid,
  input  logic [1:0]                  cmd_kind,
  input  logic [BW-1:0]               cmd_bank,
  input  logic                        cmd_ap,
  output bank_req_t [NBANK-1:0]       req
);

  cmd_kind_e kind;
  assign kind = cmd_kind_e'(cmd_kind);

  for (genvar b = 0; b < NBANK; b++) begin : g_dec
    logic hit;
    assign hit       = cmd_valid && (cmd_bank == BW'(b));
    assign req[b].act = hit && (kind == CMD_ACT);
    assign req[b].rw  = hit && ((kind == CMD_RD) || (kind == CMD_WR));
    assign req[b].wr  = hit && (kind == CMD_WR);
    assign req[b].ap  = hit && cmd_ap;
  end

endmodule

// File: rtl/ap_bank_ctl.sv
module ap_bank_ctl
  import ap_trk_pkg::*;
#(
  parameter int TRAS = 7,
  parameter int TRP  = 3,
  parameter int TWR  = 2,
  parameter int CW   = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  bank_req_t req,
  input  logic      burst_done,
  output logic      pre_start,
  output logic      ready,
  output logic      is_open
);

  localparam bit LONG_RP = (TRP > 1);

  bank_state_e state, nxt;
  logic        wr_flag;

  logic          ras_load, wr_load, rp_load;
  logic [CW-1:0] ras_cnt, wr_cnt, rp_cnt;
  logic [CW-1:0] wr_val;
  logic          ras_zero, wr_zero, rp_zero;
  logic          fire;

  assign ras_load = (state == BK_IDLE) && req.act;
  assign wr_load  = (state == BK_ARMED) && burst_done;
  assign wr_val   = wr_flag ? CW'(TWR) : '0;
  assign fire     = (state == BK_DRAIN) && ras_zero && wr_zero;
  assign rp_load  = fire;

  ap_down_timer #(.W(CW)) u_ras (
    .clk(clk), .rst_n(rst_n), .load(ras_load), .load_val(CW'(TRAS - 1)),
    .en(1'b1), .count(ras_cnt), .zero(ras_zero)
  );

  ap_down_timer #(.W(CW)) u_wrec (
    .clk(clk), .rst_n(rst_n), .load(wr_load), .load_val(wr_val),
    .en(state == BK_DRAIN), .count(wr_cnt), .zero(wr_zero)
  );

  ap_down_timer #(.W(CW)) u_rp (
    .clk(clk), .rst_n(rst_n), .load(rp_load), .load_val(CW'(TRP - 1)),
    .en(state == BK_CLOSE), .count(rp_cnt), .zero(rp_zero)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      BK_IDLE:  if (req.act) nxt = BK_OPEN;
      BK_OPEN:  if (req.rw && req.ap) nxt = BK_ARMED;
      BK_ARMED: if (burst_done) nxt = BK_DRAIN;
      BK_DRAIN: if (fire) nxt = LONG_RP ? BK_CLOSE : BK_IDLE;
      BK_CLOSE: if (rp_zero || (rp_cnt == CW'(1))) nxt = BK_IDLE;
      default:  nxt = BK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= BK_IDLE;
      wr_flag <= 1'b0;
    end else begin
      state <= nxt;
      if ((state == BK_OPEN) && req.rw && req.ap) begin
        wr_flag <= req.wr;
      end
    end
  end

  assign pre_start = fire;
  assign ready     = !(fire || (state == BK_CLOSE));
  assign is_open   = (state == BK_OPEN) || (state == BK_ARMED) || (state == BK_DRAIN);

endmodule

// File: rtl/ap_bank_tracker.sv
module ap_bank_tracker
  import ap_trk_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int TRAS  = 7,
  parameter int TRP   = 3,
  parameter int TWR   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [1:0]                 cmd_kind,
  input  logic [$clog2(NBANK)-1:0]   cmd_bank,
  input  logic                       cmd_ap,
  input  logic [NBANK-1:0]           burst_done,
  output logic [NBANK-1:0]           pre_start,
  output logic [NBANK-1:0]           bank_ready,
  output logic [NBANK-1:0]           bank_open
);

  localparam int BW    = $clog2(NBANK);
  localparam int T_AB  = (TRAS > TRP) ? TRAS : TRP;
  localparam int T_MAX = (T_AB > TWR) ? T_AB : TWR;
  localparam int CW    = $clog2(T_MAX + 1);

  bank_req_t [NBANK-1:0] req;

  ap_cmd_decode #(.NBANK(NBANK), .BW(BW)) u_dec (
    .cmd_valid(cmd_valid),
    .cmd_kind (cmd_kind),
    .cmd_bank (cmd_bank),
    .cmd_ap   (cmd_ap),
    .req      (req)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    ap_bank_ctl #(.TRAS(TRAS), .TRP(TRP), .TWR(TWR), .CW(CW)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req[b]),
      .burst_done(burst_done[b]),
      .pre_start (pre_start[b]),
      .ready     (bank_ready[b]),
      .is_open   (bank_open[b])
    );
  end

endmodule

// File: rtl/ap_bank_tracker_chk.sv
module ap_bank_tracker_chk #(
  parameter int NBANK = 4,
  parameter int BW    = 2,
  parameter int TRAS  = 7,
  parameter int TRP   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [1:0]       cmd_kind,
  input logic [BW-1:0]    cmd_bank,
  input logic [NBANK-1:0] pre_start,
  input logic [NBANK-1:0] bank_ready,
  input logic [NBANK-1:0] bank_open
);

  localparam int SW = $clog2(TRAS + 1) + 1;
  localparam int LW = $clog2(TRP + 1) + 1;

  for (genvar b = 0; b < NBANK; b++) begin : g_chk
    logic [SW-1:0] since_act;
    logic [LW-1:0] low_run;
    logic          act_ok;

    assign act_ok = cmd_valid && (cmd_kind == 2'd1) && (cmd_bank == BW'(b))
                    && bank_ready[b] && !bank_open[b];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        since_act <= '0;
        low_run   <= '0;
      end else begin
        if (act_ok) since_act <= SW'(1);
        else if (since_act < SW'(TRAS)) since_act <= since_act + 1'b1;
        if (bank_ready[b]) low_run <= '0;
        else if (low_run <= LW'(TRP)) low_run <= low_run + 1'b1;
      end
    end

    // R6: close start lasts a single cycle
    assert_pre_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pre_start[b] |=> !pre_start[b]);

    // R6: never before the row-active minimum
    assert_pre_after_tras_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pre_start[b] |-> (since_act >= SW'(TRAS)));

    // R7: close start only on an open bank
    assert_pre_on_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pre_start[b] |-> bank_open[b]);

    // R7: ready low window is exactly TRP cycles
    assert_ready_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bank_ready[b]) |-> (low_run == LW'(TRP)));

    // R7: window never overruns
    assert_ready_no_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !bank_ready[b] |-> (low_run < LW'(TRP)));

    // R8: an open bank is left only through a close start
    assert_close_via_pre_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bank_open[b]) |-> $past(pre_start[b]));
  end

endmodule

bind ap_bank_tracker ap_bank_tracker_chk #(
  .NBANK(NBANK), .BW(BW), .TRAS(TRAS), .TRP(TRP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_kind  (cmd_kind),
  .cmd_bank  (cmd_bank),
  .pre_start (pre_start),
  .bank_ready(bank_ready),
  .bank_open (bank_open)
);

// File: tb/sim_ap_bank_tracker.sv
module sim_ap_bank_tracker;

  localparam int NB   = 4;
  localparam int TRAS = 7;
  localparam int TRP  = 3;
  localparam int TWR  = 2;
  localparam int WIN  = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_kind = 2'd0;
  logic [1:0]    cmd_bank = 2'd0;
  logic          cmd_ap = 1'b0;
  logic [NB-1:0] burst_done = '0;
  logic [NB-1:0] pre_start, bank_ready, bank_open;

  int vectors = 0;
  int fails   = 0;

  always #10 clk = ~clk;

  ap_bank_tracker #(.NBANK(NB), .TRAS(TRAS), .TRP(TRP), .TWR(TWR)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .burst_done(burst_done),
    .pre_start(pre_start), .bank_ready(bank_ready), .bank_open(bank_open)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_in();
    cmd_valid  = 1'b0;
    cmd_kind   = 2'd0;
    cmd_bank   = 2'd0;
    cmd_ap     = 1'b0;
    burst_done = '0;
  endtask

  task automatic do_reset();
    clear_in();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic issue(input int kind, input int bank, input bit ap);
    cmd_valid = 1'b1;
    cmd_kind  = 2'(kind);
    cmd_bank  = 2'(bank);
    cmd_ap    = ap;
    @(negedge clk);
    clear_in();
  endtask

  task automatic done_pulse(input int bank);
    burst_done[bank] = 1'b1;
    @(negedge clk);
    clear_in();
  endtask

  task automatic run_case(input int b, input bit wr, input bit ap, input int g);
    int o, d, exp_pre, pre_rel, first_low, npre, nlow, other_bad;
    o = (b + 1) % NB;
    d = g + 1;
    exp_pre = -1;
    if (ap) begin
      exp_pre = d + 1 + (wr ? TWR : 0);
      if (exp_pre < TRAS) exp_pre = TRAS;
    end
    pre_rel = -1; first_low = -1; npre = 0; nlow = 0; other_bad = 0;
    do_reset();
    for (int rel = 0; rel < WIN; rel++) begin
      if (pre_start[b]) begin
        npre++;
        if (pre_rel < 0) pre_rel = rel;
      end
      if (!bank_ready[b]) begin
        nlow++;
        if (first_low < 0) first_low = rel;
      end
      if (pre_start[o] || !bank_ready[o]) other_bad++;
      clear_in();
      if (rel == 0) begin
        cmd_valid = 1'b1; cmd_kind = 2'd1; cmd_bank = 2'(b);
      end else if (rel == 1) begin
        cmd_valid = 1'b1; cmd_kind = wr ? 2'd3 : 2'd2; cmd_bank = 2'(b); cmd_ap = ap;
      end else if (rel == 2) begin
        cmd_valid = 1'b1; cmd_kind = 2'd1; cmd_bank = 2'(o);
      end
      if (rel == d) burst_done[b] = 1'b1;
      @(negedge clk);
    end
    clear_in();
    chk(pre_rel == exp_pre, wr ? "R5 close cycle (write)" : "R4 close cycle (read)", pre_rel, exp_pre);
    chk(npre == (ap ? 1 : 0), "R6 single close pulse", npre, ap ? 1 : 0);
    chk(nlow == (ap ? TRP : 0), "R7 ready low length", nlow, ap ? TRP : 0);
    chk(first_low == exp_pre, "R7 ready window start", first_low, exp_pre);
    chk(bank_open[b] == !ap, ap ? "R7 bank idle after close" : "R2 bank kept open", bank_open[b], !ap);
    chk(bank_open[o] && (other_bad == 0), "R9 other bank independent", other_bad, 0);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : main
    int npre, nlow;
    clear_in();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R10: reset state
    chk(bank_open == '0, "R10 open low in reset", int'(bank_open), 0);
    chk(bank_ready == '1, "R10 ready high in reset", int'(bank_ready), 15);
    chk(pre_start == '0, "R10 no close in reset", int'(pre_start), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bank_open == '0 && bank_ready == '1, "R10 idle after reset", int'(bank_open), 0);

    // R1 R2 R4 R5 R6 R7 R8 R9: sweep
    for (int b = 0; b < NB; b++)
      for (int w = 0; w < 2; w++)
        for (int a = 0; a < 2; a++)
          for (int g = 1; g <= 8; g++)
            run_case(b, w[0], a[0], g);

    // R8: commands to a closing bank are ignored
    do_reset();
    issue(1, 1, 1'b0);
    chk(bank_open[1] == 1'b1, "R1 open after row open", bank_open[1], 1);
    issue(2, 1, 1'b1);
    done_pulse(1);
    repeat (4) @(negedge clk);
    chk(pre_start[1] == 1'b1, "R4 close at TRAS", pre_start[1], 1);
    issue(1, 1, 1'b0);
    issue(2, 1, 1'b1);
    issue(1, 1, 1'b0);
    chk(bank_ready[1] == 1'b1 && bank_open[1] == 1'b0, "R8 commands while closing ignored",
        bank_open[1], 0);
    issue(1, 1, 1'b0);
    chk(bank_open[1] == 1'b1, "R1 reopen after window", bank_open[1], 1);

    // R8: read to idle bank ignored
    do_reset();
    issue(2, 3, 1'b1);
    done_pulse(3);
    repeat (TRAS + 2) @(negedge clk);
    chk(bank_open[3] == 1'b0 && bank_ready[3] == 1'b1, "R8 read to idle bank ignored",
        bank_open[3], 0);

    // R3: close request does not persist
    do_reset();
    issue(1, 2, 1'b0);
    issue(3, 2, 1'b1);
    done_pulse(2);
    repeat (15) @(negedge clk);
    chk(bank_open[2] == 1'b0, "R3 first command closes", bank_open[2], 0);
    issue(1, 2, 1'b0);
    issue(3, 2, 1'b0);
    done_pulse(2);
    npre = 0; nlow = 0;
    for (int i = 0; i < 15; i++) begin
      if (pre_start[2]) npre++;
      if (!bank_ready[2]) nlow++;
      @(negedge clk);
    end
    chk(npre == 0 && nlow == 0, "R3 later command leaves bank open", npre + nlow, 0);
    chk(bank_open[2] == 1'b1, "R3 bank still open", bank_open[2], 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule